// File: doc/BRIEF.md
# Translation Lookaside Buffer with Hardware Page-Table Refill

This block translates 32-bit virtual addresses into 30-bit physical addresses using 4 KiB pages. It keeps a small, fully associative store of recent page mappings. A request that finds its page in the store is answered on the next cycle.

A request that misses starts a hardware walk of a single-level page table. The walk reads one 32-bit word, found at the table base plus four times the virtual page number. If the word is marked valid, it is installed and the request is answered. If it is not valid, the block reports a page fault and installs nothing.

Each stored mapping carries per-entry state: a reference bit, a dirty bit, a write-permission bit and a use bit. The use bit drives an approximate-LRU victim choice. A write to a page without write permission returns a protection fault rather than a translation. Only one request is in flight at a time, and `req_ready_o` stays low while a walk is running.

Top module: `xlat_tlb`

## Requirements
- R1: On a successful translation, `rsp_paddr_o` equals the 18-bit physical page number in bits 29..12 and virtual address bits 11..0 unchanged in bits 11..0. The virtual page number is virtual address bits 31..12.
- R2: A request accepted (valid while ready) that hits gives `rsp_valid_o` high for one cycle, on the cycle after the accepting edge, with `rsp_hit_o`=1.
- R3: On a miss, `mem_req_o` rises on the cycle after acceptance, with `mem_addr_o` = `pt_base_i` + 4*VPN (modulo 2^30). It stays high until `mem_rvalid_i`. The response, with `rsp_hit_o`=0, comes on the cycle after the edge that sees `mem_rvalid_i`. A valid entry is installed, so the same page then hits.
- R4: Page-table word layout: bit 31 valid, bit 30 dirty, bit 28 write permitted (1 = writable), bits 17..0 physical page number. All other bits are ignored.
- R5: A fetched word with bit 31 clear gives `rsp_page_fault_o`=1 and `rsp_hit_o`=0, and installs nothing. A repeat request to that page walks again.
- R6: A permitted write sets the entry's dirty bit. The bit is sticky, and `rsp_dirty_o` reports the dirty bit after the access. On refill, dirty = word bit 30 OR (permitted write).
- R7: A write to a page whose permission bit is clear gives `rsp_prot_fault_o`=1 and leaves dirty unchanged. On a hit, `rsp_hit_o` stays 1. On a refill, the entry is still installed.
- R8: A refill goes to the lowest-index invalid entry. Only when all entries are valid does it go to the lowest-index entry whose use bit is clear.
- R9: Each hit or install sets that entry's use bit. If all use bits would then be set, every use bit except that entry's is cleared.
- R10: While a walk is running, `req_ready_o` is low and requests are ignored. No second walk or response results from them.
- R11: After reset, `req_ready_o`=1, `rsp_valid_o`=0, `mem_req_o`=0, and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Lookup request |
| req_ready_o | output | 1 | Block can accept a request |
| req_vaddr_i | input | 32 | Virtual address |
| req_write_i | input | 1 | 1 = write access |
| pt_base_i | input | 30 | Page-table base byte address |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_paddr_o | output | 30 | Physical address |
| rsp_hit_o | output | 1 | Translation came from the buffer |
| rsp_page_fault_o | output | 1 | Page-table word was invalid |
| rsp_prot_fault_o | output | 1 | Write denied by permission bit |
| rsp_dirty_o | output | 1 | Entry dirty bit after this access |
| mem_req_o | output | 1 | Page-table read request (level) |
| mem_addr_o | output | 30 | Page-table word address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Page-table word |

## Verification
A hit is due exactly one cycle after its accepting edge. A miss is due one cycle after the edge at which the bench's memory model returns data. With the model's fixed three-cycle read delay, a miss response appears four sampling points after acceptance. The bench drives and samples on falling edges and counts falling edges from acceptance to `rsp_valid_o`, so every response is checked against its exact latency rather than by waiting open-endedly. Page-table addresses are captured when the model first sees `mem_req_o`, and request counts are compared across the window in which requests are held during a walk.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W  = 32;
  localparam int PA_W  = 30;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int PTE_W = 32;
  localparam int PTE_V_BIT = 31;
  localparam int PTE_D_BIT = 30;
  localparam int PTE_R_BIT = 29;
  localparam int PTE_W_BIT = 28;

  typedef struct packed {
    logic             valid;
    logic [VPN_W-1:0] tag;
    logic [PPN_W-1:0] ppn;
    logic             dirty;
    logic             refd;
    logic             wr_ok;
  } ent_t;
endpackage

// File: rtl/xlat_match.sv
module xlat_match import xlat_pkg::*; #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [VPN_W-1:0]   tag_i [ENTRIES],
  input  logic [VPN_W-1:0]   vpn_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (tag_i[g] == vpn_i);
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) idx_o = IDX_W'(i);
  end

  assign hit_o = |match;
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ENTRIES-1:0] use_i,
  output logic [IDX_W-1:0]   idx_o
);
  logic free_found, old_found;
  logic [IDX_W-1:0] free_idx, old_idx;

  always_comb begin
    free_found = 1'b0;
    old_found  = 1'b0;
    free_idx   = '0;
    old_idx    = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!free_found && !valid_i[i]) begin
        free_idx   = IDX_W'(i);
        free_found = 1'b1;
      end
      if (!old_found && !use_i[i]) begin
        old_idx   = IDX_W'(i);
        old_found = 1'b1;
      end
    end
    idx_o = free_found ? free_idx : old_idx;
  end
endmodule

// File: rtl/xlat_age.sv
module xlat_age #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] use_i,
  input  logic               touch_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [ENTRIES-1:0] use_o
);
  logic [ENTRIES-1:0] marked;

  always_comb begin
    marked = use_i;
    if (touch_i) marked[idx_i] = 1'b1;
    use_o = marked;
    // saturation: keep only the newest
    if (touch_i && (&marked)) begin
      use_o        = '0;
      use_o[idx_i] = 1'b1;
    end
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb import xlat_pkg::*; #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_write_i,
  input  logic [PA_W-1:0]  pt_base_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             rsp_hit_o,
  output logic             rsp_page_fault_o,
  output logic             rsp_prot_fault_o,
  output logic             rsp_dirty_o,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [PTE_W-1:0] mem_rdata_i
);
  typedef enum logic {S_IDLE, S_WALK} st_t;

  st_t                st_q;
  ent_t               tlb_q [ENTRIES];
  logic [ENTRIES-1:0] use_q, use_d, valid_vec;
  logic [VPN_W-1:0]   tag_arr [ENTRIES];
  logic [VPN_W-1:0]   vpn_q;
  logic [OFF_W-1:0]   off_q;
  logic               wr_q;

  logic               lk_hit;
  logic [IDX_W-1:0]   lk_idx, vic_idx, touch_idx;
  logic               accept, touch_en, fill_ok;
  logic               pte_v, pte_d, pte_w;
  logic [PPN_W-1:0]   pte_ppn;
  ent_t               he;
  logic               hit_wr_ok;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
    assign valid_vec[g] = tlb_q[g].valid;
    assign tag_arr[g]   = tlb_q[g].tag;
  end

  xlat_match #(.ENTRIES(ENTRIES)) u_match (
    .valid_i(valid_vec), .tag_i(tag_arr),
    .vpn_i(req_vaddr_i[VA_W-1:OFF_W]), .hit_o(lk_hit), .idx_o(lk_idx)
  );

  xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
    .valid_i(valid_vec), .use_i(use_q), .idx_o(vic_idx)
  );

  xlat_age #(.ENTRIES(ENTRIES)) u_age (
    .use_i(use_q), .touch_i(touch_en), .idx_i(touch_idx), .use_o(use_d)
  );

  assign req_ready_o = (st_q == S_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign mem_req_o   = (st_q == S_WALK);
  assign mem_addr_o  = pt_base_i + {{(PA_W-VPN_W-2){1'b0}}, vpn_q, 2'b00};

  assign pte_v   = mem_rdata_i[PTE_V_BIT];
  assign pte_d   = mem_rdata_i[PTE_D_BIT];
  assign pte_w   = mem_rdata_i[PTE_W_BIT];
  assign pte_ppn = mem_rdata_i[PPN_W-1:0];

  assign he        = tlb_q[lk_idx];
  assign hit_wr_ok = req_write_i && he.wr_ok;
  assign fill_ok   = (st_q == S_WALK) && mem_rvalid_i && pte_v;
  assign touch_en  = (accept && lk_hit) || fill_ok;
  assign touch_idx = (st_q == S_WALK) ? vic_idx : lk_idx;

  logic unused_ok;
  assign unused_ok = ^{mem_rdata_i[PTE_R_BIT], mem_rdata_i[27:PPN_W], he.refd, he.valid, he.tag};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q             <= S_IDLE;
      use_q            <= '0;
      vpn_q            <= '0;
      off_q            <= '0;
      wr_q             <= 1'b0;
      rsp_valid_o      <= 1'b0;
      rsp_paddr_o      <= '0;
      rsp_hit_o        <= 1'b0;
      rsp_page_fault_o <= 1'b0;
      rsp_prot_fault_o <= 1'b0;
      rsp_dirty_o      <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) tlb_q[i] <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      use_q       <= use_d;
      unique case (st_q)
        S_IDLE: if (accept) begin
          if (lk_hit) begin
            rsp_valid_o           <= 1'b1;
            rsp_hit_o             <= 1'b1;
            rsp_page_fault_o      <= 1'b0;
            rsp_prot_fault_o      <= req_write_i && !he.wr_ok;
            rsp_paddr_o           <= {he.ppn, req_vaddr_i[OFF_W-1:0]};
            rsp_dirty_o           <= he.dirty || hit_wr_ok;
            tlb_q[lk_idx].refd    <= 1'b1;
            if (hit_wr_ok) tlb_q[lk_idx].dirty <= 1'b1;
          end else begin
            st_q  <= S_WALK;
            vpn_q <= req_vaddr_i[VA_W-1:OFF_W];
            off_q <= req_vaddr_i[OFF_W-1:0];
            wr_q  <= req_write_i;
          end
        end
        S_WALK: if (mem_rvalid_i) begin
          st_q        <= S_IDLE;
          rsp_valid_o <= 1'b1;
          rsp_hit_o   <= 1'b0;
          if (pte_v) begin
            tlb_q[vic_idx]   <= '{valid: 1'b1, tag: vpn_q, ppn: pte_ppn,
                                  dirty: pte_d || (wr_q && pte_w),
                                  refd: 1'b1, wr_ok: pte_w};
            rsp_paddr_o      <= {pte_ppn, off_q};
            rsp_page_fault_o <= 1'b0;
            rsp_prot_fault_o <= wr_q && !pte_w;
            rsp_dirty_o      <= pte_d || (wr_q && pte_w);
          end else begin
            rsp_paddr_o      <= '0;
            rsp_page_fault_o <= 1'b1;
            rsp_prot_fault_o <= 1'b0;
            rsp_dirty_o      <= 1'b0;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk import xlat_pkg::*; (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [VA_W-1:0]  req_vaddr_i,
  input logic             rsp_valid_o,
  input logic [PA_W-1:0]  rsp_paddr_o,
  input logic             rsp_hit_o,
  input logic             rsp_page_fault_o,
  input logic             rsp_prot_fault_o,
  input logic             mem_req_o,
  input logic             mem_rvalid_i
);
  // R2
  accept_answers_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> rsp_valid_o || mem_req_o);

  // R1
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_valid_i && req_ready_o) && rsp_valid_o && rsp_hit_o && !rsp_prot_fault_o
    |-> rsp_paddr_o[OFF_W-1:0] == $past(req_vaddr_i[OFF_W-1:0]));

  // R3
  walk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o);

  // R3
  walk_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_rvalid_i |=> rsp_valid_o && !rsp_hit_o);

  // R5
  fault_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_page_fault_o && rsp_valid_o |-> !rsp_hit_o && !rsp_prot_fault_o);

  // R10
  busy_noready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);
endmodule

bind xlat_tlb xlat_tlb_chk u_chk (.*);

// File: tb/xlat_tlb_test.sv
module xlat_tlb_test;
  localparam logic [29:0] BASE = 30'h0010_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_vaddr_i = '0;
  logic        req_write_i = 1'b0;
  logic [29:0] pt_base_i = BASE;
  logic        rsp_valid_o;
  logic [29:0] rsp_paddr_o;
  logic        rsp_hit_o, rsp_page_fault_o, rsp_prot_fault_o, rsp_dirty_o;
  logic        mem_req_o;
  logic [29:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  always #2.5 clk_i = ~clk_i;

  xlat_tlb uut (.*);

  int checks = 0, fails = 0, cyc = 0;
  int mem_cnt = 0, rsp_cnt = 0, busy_ready = 0;
  logic [29:0] last_addr = '0;

  function automatic logic [17:0] ppn_of(input logic [19:0] v);
    return v[17:0] ^ 18'h2A5A5;
  endfunction
  // valid unless vpn bit 8; writable unless bit 9; dirty if bit 10
  function automatic logic [31:0] pte_of(input logic [29:0] a);
    logic [19:0] v;
    v = 20'((a - BASE) >> 2);
    return {~v[8], v[10], 1'b0, ~v[9], 10'b0, ppn_of(v)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: read data three falling edges after the request is seen
  int mcnt = 0; bit mbusy = 0;
  always @(negedge clk_i) begin
    if (mem_rvalid_i) begin
      mem_rvalid_i <= 1'b0; mbusy <= 0;
    end else if (mbusy) begin
      mcnt <= mcnt - 1;
      if (mcnt == 1) begin
        mem_rvalid_i <= 1'b1; mem_rdata_i <= pte_of(last_addr);
      end
    end else if (mem_req_o) begin
      mbusy <= 1; mcnt <= 2; last_addr <= mem_addr_o; mem_cnt++;
    end
    if (rsp_valid_o) rsp_cnt++;
    if (mem_req_o && req_ready_o) busy_ready++;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  logic o_hit, o_pf, o_prot, o_dirty;
  logic [29:0] o_pa;
  int lat;

  task automatic lookup(input logic [31:0] va, input logic wr);
    @(negedge clk_i);
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1'b1; req_vaddr_i = va; req_write_i = wr;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    lat = 1;
    while (!rsp_valid_o) begin @(negedge clk_i); lat++; end
    o_hit = rsp_hit_o; o_pf = rsp_page_fault_o; o_prot = rsp_prot_fault_o;
    o_dirty = rsp_dirty_o; o_pa = rsp_paddr_o;
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); @(negedge clk_i); rst_ni = 1'b1;
  endtask

  // {write, vpn, offset, hit, page fault, prot fault, dirty}
  localparam logic [36:0] VEC [12] = '{
    {1'b0, 20'h00003, 12'h123, 4'b0000},
    {1'b0, 20'h00003, 12'hABC, 4'b1000},
    {1'b1, 20'h00003, 12'h004, 4'b1001},
    {1'b0, 20'h00003, 12'hFFF, 4'b1001},
    {1'b0, 20'h00100, 12'h010, 4'b0100},
    {1'b0, 20'h00100, 12'h020, 4'b0100},
    {1'b1, 20'h00200, 12'h030, 4'b0010},
    {1'b0, 20'h00200, 12'h040, 4'b1000},
    {1'b1, 20'h00200, 12'h050, 4'b1010},
    {1'b1, 20'h00005, 12'h060, 4'b0001},
    {1'b0, 20'h00400, 12'h070, 4'b0001},
    {1'b0, 20'h00005, 12'h080, 4'b1001}
  };

  initial begin
    int m0, r0;
    repeat (2) @(negedge clk_i);
    // R11 reset state
    chk(req_ready_o == 1'b1, "R11 ready", 64'(req_ready_o), 1);
    chk(rsp_valid_o == 1'b0, "R11 rsp_valid", 64'(rsp_valid_o), 0);
    chk(mem_req_o == 1'b0, "R11 mem_req", 64'(mem_req_o), 0);
    rst_ni = 1'b1;

    for (int i = 0; i < 12; i++) begin
      logic [36:0] v;
      logic [31:0] va;
      v = VEC[i];
      va = {v[35:16], v[15:4]};
      lookup(va, v[36]);
      chk(o_hit == v[3], $sformatf("R2/R3 hit row %0d", i), 64'(o_hit), 64'(v[3]));
      chk(o_pf == v[2], $sformatf("R5 page fault row %0d", i), 64'(o_pf), 64'(v[2]));
      chk(o_prot == v[1], $sformatf("R7 prot fault row %0d", i), 64'(o_prot), 64'(v[1]));
      chk(lat == (v[3] ? 1 : 4), $sformatf("R2/R3 latency row %0d", i), 64'(lat), v[3] ? 1 : 4);
      if (!v[2] && !v[1]) begin
        chk(o_dirty == v[0], $sformatf("R6 dirty row %0d", i), 64'(o_dirty), 64'(v[0]));
        chk(o_pa == {ppn_of(v[35:16]), v[15:4]}, $sformatf("R1 R4 paddr row %0d", i),
            64'(o_pa), 64'({ppn_of(v[35:16]), v[15:4]}));
      end
      if (!v[3])
        chk(last_addr == BASE + {8'b0, v[35:16], 2'b00}, $sformatf("R3 walk addr row %0d", i),
            64'(last_addr), 64'(BASE + {8'b0, v[35:16], 2'b00}));
    end

    // R11 reset invalidates every entry
    do_reset();
    lookup({20'h00003, 12'h0}, 1'b0);
    chk(o_hit == 1'b0, "R11 entries cleared", 64'(o_hit), 0);

    // R8 R9 replacement
    do_reset();
    for (int i = 0; i < 16; i++) lookup({20'h10 + 20'(i), 12'h0}, 1'b0);
    lookup({20'h10, 12'h0}, 1'b0);
    chk(o_hit == 1'b1, "R8 fill uses free entries", 64'(o_hit), 1);
    lookup({20'h30, 12'h0}, 1'b0);   // evicts entry 1 (vpn 0x11); use {0,15}->{0,1,15}? see below
    // after fill use={15}; hit 0x10 -> {0,15}; miss 0x30 -> victim 1 (vpn 0x11)
    lookup({20'h11, 12'h0}, 1'b0);
    chk(o_hit == 1'b0, "R9 oldest evicted", 64'(o_hit), 0);
    // 0x11 refilled into entry 2 (vpn 0x12 evicted); use {0,1,2,15}
    lookup({20'h13, 12'h0}, 1'b0);
    chk(o_hit == 1'b1, "R9 unused kept", 64'(o_hit), 1);
    lookup({20'h12, 12'h0}, 1'b0);
    chk(o_hit == 1'b0, "R9 second victim", 64'(o_hit), 0);
    lookup({20'h1F, 12'h0}, 1'b0);
    chk(o_hit == 1'b1, "R9 newest survives saturation", 64'(o_hit), 1);
    lookup({20'h30, 12'h0}, 1'b0);
    chk(o_hit == 1'b1, "R8 installed entry hits", 64'(o_hit), 1);

    // R10 requests ignored during a walk
    @(negedge clk_i);
    m0 = mem_cnt; r0 = rsp_cnt;
    req_valid_i = 1'b1; req_vaddr_i = {20'h60, 12'h345}; req_write_i = 1'b0;
    @(negedge clk_i);
    req_vaddr_i = {20'h61, 12'h0};
    chk(req_ready_o == 1'b0, "R10 ready low in walk", 64'(req_ready_o), 0);
    @(negedge clk_i); @(negedge clk_i);
    req_valid_i = 1'b0;
    while (!rsp_valid_o) @(negedge clk_i);
    chk(rsp_paddr_o == {ppn_of(20'h60), 12'h345}, "R10 first request answered",
        64'(rsp_paddr_o), 64'({ppn_of(20'h60), 12'h345}));
    repeat (3) @(negedge clk_i);
    chk(mem_cnt - m0 == 1, "R10 one walk", 64'(mem_cnt - m0), 1);
    chk(rsp_cnt - r0 == 1, "R10 one response", 64'(rsp_cnt - r0), 1);
    lookup({20'h61, 12'h0}, 1'b0);
    chk(o_hit == 1'b0, "R10 held request not installed", 64'(o_hit), 0);
    chk(busy_ready == 0, "R10 ready during walk", 64'(busy_ready), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule